// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block merges transmit-completion interrupts so that a burst of finished descriptors can raise one interrupt rather than many. Each descriptor write-back arrives as a one-cycle event carrying an 8-bit command byte. Two bits of that byte matter here. One asks for status to be reported. The other asks for the report to be delayed. A write-back that carries both bits starts a countdown from a programmed delay value, or starts it again if it is already running. The counter steps down once on each tick strobe, which comes from an external prescaler. When the counter reaches zero, one interrupt pulse is raised.

A write-back that asks for a report but does not ask for a delay raises the interrupt at once and drops any countdown that is still pending. As a result, the earlier countdown never produces a second pulse. A single enable input gates every interrupt this block produces. The output is a registered pulse, one clock wide.

Top module: `tx_irq_coalescer`

## Requirements
- R1: A write-back (`wb_valid`=1) with command bit 7 (delay) and bit 3 (report) both set and `delay_val`=D>0 arms the timer. No interrupt is raised for that write-back itself. Exactly one `irq_pulse` follows, in the cycle after the clock edge that samples the D-th tick.
- R2: A second arming write-back made while the count is running restarts the count from the new delay value. The pulse then comes D ticks after that second write-back.
- R3: The count changes only on edges where `tick` is high. Clock cycles without a tick leave an armed count unchanged.
- R4: A write-back with bit 3 set and bit 7 clear gives `irq_pulse` in the cycle after the write-back edge.
- R5: The R4 case also clears the countdown, so no later pulse comes from an earlier arming.
- R6: An arming write-back on the same edge where a tick would take the count to zero wins. No pulse is raised that cycle, and the count restarts.
- R7: After reset, and whenever the timer is not armed, the count stays at zero and no pulse is raised, whatever `tick` does.
- R8: An arming write-back with `delay_val`=0 acts like R4: an immediate pulse and no later one.
- R9: While `irq_en` is low, no pulse is raised, either from expiry or from the immediate case. An expiry that occurs while `irq_en` is low is dropped.
- R10: A write-back with bit 3 clear, or command bits presented while `wb_valid` is low, leaves the timer untouched.
- R11: Each interrupt event gives an `irq_pulse` exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Descriptor write-back event, one cycle |
| wb_cmd | input | CMD_W | Command byte of the written-back descriptor |
| delay_val | input | CNT_W | Programmed delay, in ticks |
| irq_en | input | 1 | Interrupt enable |
| tick | input | 1 | Prescaled time strobe |
| irq_pulse | output | 1 | Transmit interrupt pulse |

## Verification
Every result is registered once. An immediate interrupt is therefore visible in the cycle after the write-back edge, and an expiry interrupt in the cycle after the edge that samples the D-th tick. The bench drives each input on a falling edge and reads `irq_pulse` on the next falling edge, so each reading belongs to exactly one sampling edge. Expiry checks count elapsed steps from the arming write-back and compare the step of the first pulse with D times the tick period. They also count pulses over a tail window to confirm that exactly one arrived.

// File: rtl/txc_pkg.sv
package txc_pkg;
   // Action decoded from one write-back event
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_ARM  = 2'd1,
      ACT_FIRE = 2'd2
   } txc_act_e;
endpackage

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
   import txc_pkg::*;
#(
   parameter int CMD_W   = 8,
   parameter int CNT_W   = 16,
   parameter int DLY_BIT = 7,
   parameter int RPT_BIT = 3
) (
   input  logic             valid_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [CNT_W-1:0] delay_i,
   output txc_act_e         act_o
);
   logic want_rpt, want_dly, zero_dly;

   always_comb begin
      want_rpt = valid_i & cmd_i[RPT_BIT];
      want_dly = cmd_i[DLY_BIT];
      zero_dly = (delay_i == '0);
      act_o    = ACT_NONE;
      if (want_rpt) begin
         // R8: a zero delay degenerates to an immediate report
         if (want_dly && !zero_dly) act_o = ACT_ARM;
         else                       act_o = ACT_FIRE;
      end
   end
endmodule

// File: rtl/txc_countdown.sv
module txc_countdown
   import txc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  txc_act_e         act_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] delay_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   // R6: any write-back action overrides expiry in the same cycle
   always_comb expire_o = (act_i == ACT_NONE) && tick_i && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (act_i == ACT_ARM)          cnt_q <= delay_i;
      else if (act_i == ACT_FIRE)         cnt_q <= '0;
      else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
   end

   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_ARM) |=> (cnt_q == $past(delay_i)));
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_FIRE) |=> (cnt_q == '0));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_NONE && !tick_i) |=> $stable(cnt_q));
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_NONE && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/txc_irq_gen.sv
module txc_irq_gen #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic en_i,
   output logic irq_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= req_i & en_i;
         end
         assign irq_o = irq_q;

         a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |=> !irq_o);
      end else begin : g_comb
         assign irq_o = req_i & en_i & rst_n;
      end
   endgenerate
endmodule

// File: rtl/tx_irq_coalescer.sv
module tx_irq_coalescer
   import txc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int CMD_W   = 8,
   parameter int DLY_BIT = 7,
   parameter int RPT_BIT = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wb_valid,
   input  logic [CMD_W-1:0] wb_cmd,
   input  logic [CNT_W-1:0] delay_val,
   input  logic             irq_en,
   input  logic             tick,
   output logic             irq_pulse
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (DLY_BIT >= CMD_W || RPT_BIT >= CMD_W || DLY_BIT == RPT_BIT) begin : g_bad_bits
         $error("command bit positions invalid");
      end
   endgenerate

   txc_act_e act;
   logic     expire;
   logic     fire_req;

   txc_cmd_decode #(
      .CMD_W(CMD_W), .CNT_W(CNT_W), .DLY_BIT(DLY_BIT), .RPT_BIT(RPT_BIT)
   ) u_dec (
      .valid_i(wb_valid), .cmd_i(wb_cmd), .delay_i(delay_val), .act_o(act)
   );

   txc_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .act_i(act), .tick_i(tick),
      .delay_i(delay_val), .expire_o(expire)
   );

   always_comb fire_req = expire | (act == ACT_FIRE);

   txc_irq_gen #(.OUT_REG(OUT_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .req_i(fire_req), .en_i(irq_en), .irq_o(irq_pulse)
   );

   generate
      if (OUT_REG) begin : g_chk
         a_r4_immediate: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid && wb_cmd[RPT_BIT] && !wb_cmd[DLY_BIT] && irq_en) |=> irq_pulse);
         a_r6_arm_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (act == ACT_ARM) |=> !irq_pulse);
         a_r10_no_report: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid && !wb_cmd[RPT_BIT] && !tick) |=> !irq_pulse);
      end
   endgenerate
endmodule

// File: tb/sim_tx_irq_coalescer.sv
`timescale 1ns/1ps
module sim_tx_irq_coalescer;
   localparam int CW = 4;
   localparam logic [7:0] C_ARM = 8'h88;
   localparam logic [7:0] C_RPT = 8'h08;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wb_valid = 1'b0;
   logic [7:0]    wb_cmd = '0;
   logic [CW-1:0] dly = '0;
   logic          irq_en = 1'b1;
   logic          tick = 1'b0;
   logic          irq;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tx_irq_coalescer #(.CNT_W(CW), .CMD_W(8), .DLY_BIT(7), .RPT_BIT(3), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_cmd(wb_cmd),
      .delay_val(dly), .irq_en(irq_en), .tick(tick), .irq_pulse(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic t, output logic p);
      tick = t;
      @(negedge clk);
      p = irq;
      tick = 1'b0;
   endtask

   task automatic wb(input logic [7:0] c, input int d, input logic t, output logic p);
      wb_valid = 1'b1; wb_cmd = c; dly = d[CW-1:0]; tick = t;
      @(negedge clk);
      p = irq;
      wb_valid = 1'b0; wb_cmd = '0; tick = 1'b0;
   endtask

   task automatic run(input int n, input int per, output int first, output int cnt);
      first = -1; cnt = 0;
      for (int c = 1; c <= n; c++) begin
         logic p;
         step((c % per) == 0, p);
         if (p) begin
            cnt++;
            if (first < 0) first = c;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic p;
      int f, n;
      repeat (3) @(negedge clk);
      chk(irq == 1'b0, "R7 reset", irq, 0);
      rst_n = 1'b1;
      run(10, 1, f, n);
      chk(n == 0, "R7 idle after reset", n, 0);

      // R1 / R3 / R11 sweep over delay and tick period
      for (int per = 1; per <= 3; per += 2) begin
         for (int d = 1; d < (1 << CW); d++) begin
            wb((d % 2) ? C_ARM : 8'hFF, d, 1'b0, p);
            chk(p == 1'b0, "R1 no pulse on arm", p, 0);
            run(d * per + 6, per, f, n);
            chk(f == d * per, "R1 R3 expiry step", f, d * per);
            chk(n == 1, "R11 single pulse", n, 1);
         end
      end

      // R3: no ticks, count holds
      wb(C_ARM, 2, 1'b0, p);
      run(20, 1000, f, n);
      chk(n == 0, "R3 hold without tick", n, 0);
      run(5, 1, f, n);
      chk(f == 2, "R3 resume after hold", f, 2);

      // R2 restart
      wb(C_ARM, 5, 1'b0, p);
      run(3, 1, f, n);
      chk(n == 0, "R2 before restart", n, 0);
      wb(C_ARM, 5, 1'b0, p);
      chk(p == 1'b0, "R2 restart no pulse", p, 0);
      run(10, 1, f, n);
      chk(f == 5, "R2 restart expiry", f, 5);
      chk(n == 1, "R2 single pulse", n, 1);

      // R4 / R5 immediate and cancel
      wb(C_ARM, 6, 1'b0, p);
      run(2, 1, f, n);
      wb(C_RPT, 9, 1'b0, p);
      chk(p == 1'b1, "R4 immediate pulse", p, 1);
      run(12, 1, f, n);
      chk(n == 0, "R5 countdown cancelled", n, 0);

      // R8 zero delay
      wb(C_ARM, 0, 1'b0, p);
      chk(p == 1'b1, "R8 zero delay immediate", p, 1);
      run(20, 1, f, n);
      chk(n == 0, "R8 no later pulse", n, 0);

      // R6 reload coinciding with expiry
      wb(C_ARM, 3, 1'b0, p);
      run(2, 1, f, n);
      chk(n == 0, "R6 before collision", n, 0);
      wb(C_ARM, 3, 1'b1, p);
      chk(p == 1'b0, "R6 reload wins", p, 0);
      run(6, 1, f, n);
      chk(f == 3, "R6 restarted expiry", f, 3);

      // R9 enable gating
      irq_en = 1'b0;
      wb(C_ARM, 2, 1'b0, p);
      run(5, 1, f, n);
      chk(n == 0, "R9 expiry suppressed", n, 0);
      wb(C_RPT, 2, 1'b0, p);
      chk(p == 1'b0, "R9 immediate suppressed", p, 0);
      irq_en = 1'b1;
      run(5, 1, f, n);
      chk(n == 0, "R9 nothing pending", n, 0);

      // R10 ignored write-backs
      wb(C_ARM, 4, 1'b0, p);
      wb(8'h80, 1, 1'b0, p);
      chk(p == 1'b0, "R10 delay bit only", p, 0);
      wb(8'hF7, 1, 1'b0, p);
      chk(p == 1'b0, "R10 report bit clear", p, 0);
      wb_cmd = C_RPT; dly = 4'd1;
      step(1'b0, p);
      wb_cmd = '0;
      chk(p == 1'b0, "R10 valid low", p, 0);
      run(10, 1, f, n);
      chk(f == 4, "R10 timer untouched", f, 4);
      chk(n == 1, "R11 single pulse", n, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule